// File: doc/BRIEF.md
# I2C Bus Interrupt Status Unit

This unit holds, for one I2C master bus, an interrupt enable register and an interrupt status register. The command sequencer reports what happened on the bus through single-cycle event pulses: address or data acknowledged, not acknowledged, a received byte ready, a clean stop, and a stop issued with no transfer active. Each pulse sets its status bit only if that bit is enabled. The unit then drives a level interrupt line and a one-bit summary flag that the controller-level logic ORs across buses.

Software reads both registers through a small valid/write/address/data port. It clears status bits by writing ones to them. A receive may be split into steps. If software acknowledges a pending receive-done while the sequencer still has a receive or last-receive command outstanding, the unit pulses a continue request back to the sequencer. The sequencer then performs the next step and reports it with a fresh event.

Top module: `i2c_irq_unit`

## Requirements
- R1: After a synchronous reset, the enable and status registers read zero and `irq`, `bus_summary` and `rx_continue` are low.
- R2: A write to the enable register (offset 0) stores `reg_wdata[14:0]` only. Bits 31:15 read back as zero.
- R3: Status bit positions are tx_ack=0, tx_nak=1, rx_done=2, stop_bad=3 and stop_ok=4. An event pulse for an enabled bit sets that bit. `irq` and `bus_summary` go high at the same clock edge.
- R4: An event pulse whose bit is disabled leaves that status bit clear and does not raise `irq`.
- R5: At any edge where at least one event arrives, held status bits whose enable is currently off are dropped.
- R6: A write to the status register (offset 1) clears every bit of `reg_wdata[14:0]` that is one. Bits written as zero and bits 31:15 of the write data have no effect.
- R7: `irq` and `bus_summary` are high exactly while any status bit is held. They fall at the edge where the last bit is cleared.
- R8: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: A status write with bit 2 set, while rx_done is held and `rx_pending` is high, produces a one-cycle `rx_continue` pulse. The pulse starts at that write's clock edge.
- R10: No `rx_continue` pulse is produced if `rx_pending` is low, if rx_done is not held, or if the write leaves bit 2 at zero.
- R11: Reads have no side effects. `reg_rdata` shows the addressed register combinationally, and any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| ev_tx_ack | input | 1 | Event: transfer acknowledged |
| ev_tx_nak | input | 1 | Event: transfer not acknowledged |
| ev_rx_done | input | 1 | Event: received byte ready |
| ev_stop_bad | input | 1 | Event: stop requested while not active |
| ev_stop_ok | input | 1 | Event: normal stop completed |
| rx_pending | input | 1 | Sequencer has a receive or last-receive command outstanding |
| irq | output | 1 | Level interrupt |
| bus_summary | output | 1 | Per-bus summary flag for the controller |
| rx_continue | output | 1 | One-cycle request to run the next receive step |

## Verification
The bench first checks that an event for a disabled bit is discarded rather than latched; a design that latched it would raise the interrupt when software later enabled the bit. It also checks that a later event purges bits that were disabled after being set; a design that skipped this would keep a stale bit holding the line high. A clear and an event on the same bit in the same cycle must leave the bit set, or a completion is lost. Finally, the bench drives every combination of missing condition for the continue request, so a design that fired on any status write, or without a pending receive, would restart the sequencer spuriously.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int FIELD_W = 15;

    localparam int B_TX_ACK   = 0;
    localparam int B_TX_NAK   = 1;
    localparam int B_RX_DONE  = 2;
    localparam int B_STOP_BAD = 3;
    localparam int B_STOP_OK  = 4;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic tx_ack;
        logic tx_nak;
        logic rx_done;
        logic stop_bad;
        logic stop_ok;
    } ev_t;

    typedef struct packed {
        logic   en_we;
        logic   st_we;
        field_t wdata;
    } regop_t;

    function automatic field_t ev_to_field(ev_t e);
        field_t f;
        f = '0;
        f[B_TX_ACK]   = e.tx_ack;
        f[B_TX_NAK]   = e.tx_nak;
        f[B_RX_DONE]  = e.rx_done;
        f[B_STOP_BAD] = e.stop_bad;
        f[B_STOP_OK]  = e.stop_ok;
        return f;
    endfunction

endpackage

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int EN_OFS = 0,
    parameter int ST_OFS = 1
) (
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  field_t            enable_q,
    input  field_t            status_q,
    output regop_t            op,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_W = DATA_W - FIELD_W;
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_OFS);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_OFS);

    logic wr;
    assign wr = reg_valid && reg_write;

    always_comb begin
        op.en_we = wr && (reg_addr == EN_A);
        op.st_we = wr && (reg_addr == ST_A);
        op.wdata = reg_wdata[FIELD_W-1:0];
    end

    always_comb begin
        if (reg_addr == EN_A)
            reg_rdata = {{PAD_W{1'b0}}, enable_q};
        else if (reg_addr == ST_A)
            reg_rdata = {{PAD_W{1'b0}}, status_q};
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/i2c_irq_core.sv
module i2c_irq_core
    import i2c_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  regop_t op,
    input  ev_t    ev,
    output field_t enable_q,
    output field_t status_q,
    output logic   irq_q
);
    field_t set_v, clr_v, kept, nxt;
    logic   any_ev;

    always_comb begin
        set_v  = ev_to_field(ev);
        clr_v  = op.st_we ? op.wdata : '0;
        any_ev = |set_v;
        kept   = status_q & ~clr_v;
        nxt    = any_ev ? ((kept | set_v) & enable_q) : kept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (op.en_we)
                enable_q <= op.wdata;
            status_q <= nxt;
            irq_q    <= |nxt;
        end
    end
endmodule

// File: rtl/i2c_irq_rx_resume.sv
module i2c_irq_rx_resume
    import i2c_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  regop_t op,
    input  field_t status_q,
    input  logic   rx_pending,
    output logic   rx_continue_q
);
    logic go;
    assign go = op.st_we && op.wdata[B_RX_DONE] && status_q[B_RX_DONE] && rx_pending;

    always_ff @(posedge clk) begin
        if (rst) rx_continue_q <= 1'b0;
        else     rx_continue_q <= go;
    end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int EN_OFS = 0,
    parameter int ST_OFS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_tx_ack,
    input  logic              ev_tx_nak,
    input  logic              ev_rx_done,
    input  logic              ev_stop_bad,
    input  logic              ev_stop_ok,
    input  logic              rx_pending,
    output logic              irq,
    output logic              bus_summary,
    output logic              rx_continue
);
    regop_t op;
    ev_t    ev;
    field_t enable_q, status_q;
    logic   irq_q;

    assign ev = '{tx_ack: ev_tx_ack, tx_nak: ev_tx_nak, rx_done: ev_rx_done,
                  stop_bad: ev_stop_bad, stop_ok: ev_stop_ok};

    i2c_irq_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFS(EN_OFS), .ST_OFS(ST_OFS)
    ) u_regif (
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .enable_q(enable_q), .status_q(status_q),
        .op(op), .reg_rdata(reg_rdata)
    );

    i2c_irq_core u_core (
        .clk(clk), .rst(rst), .op(op), .ev(ev),
        .enable_q(enable_q), .status_q(status_q), .irq_q(irq_q)
    );

    i2c_irq_rx_resume u_resume (
        .clk(clk), .rst(rst), .op(op), .status_q(status_q),
        .rx_pending(rx_pending), .rx_continue_q(rx_continue)
    );

    assign irq         = irq_q;
    assign bus_summary = irq_q;
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk #(
    parameter int ADDR_W = 4,
    parameter int ST_OFS = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]        wlow,
    input logic              ev_tx_ack,
    input logic              ev_tx_nak,
    input logic              ev_rx_done,
    input logic              rx_pending,
    input logic [2:0]        en_low,
    input logic [2:0]        st_low,
    input logic              st_any,
    input logic              irq,
    input logic              rx_continue
);
    logic st_hit;
    assign st_hit = reg_valid && reg_write && (reg_addr == ADDR_W'(ST_OFS));

    p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
        irq == st_any);

    p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ev_tx_ack && en_low[0] |=> st_low[0]);

    p_disabled_drop_r4: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done && !en_low[2] && !st_low[2] |=> !st_low[2]);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        st_hit && wlow[1] && !ev_tx_nak |=> !st_low[1]);

    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ev_tx_ack && en_low[0] && st_hit && wlow[0] |=> st_low[0]);

    p_cont_cause_r9: assert property (@(posedge clk) disable iff (rst)
        rx_continue |-> $past(rx_pending && st_hit && wlow[2] && st_low[2]));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.ADDR_W(ADDR_W), .ST_OFS(ST_OFS)) u_chk (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .wlow(reg_wdata[2:0]), .ev_tx_ack(ev_tx_ack),
    .ev_tx_nak(ev_tx_nak), .ev_rx_done(ev_rx_done), .rx_pending(rx_pending),
    .en_low(enable_q[2:0]), .st_low(status_q[2:0]), .st_any(|status_q),
    .irq(irq), .rx_continue(rx_continue)
);

// File: tb/i2c_irq_unit_bench.sv
`timescale 1ns/1ps
module i2c_irq_unit_bench;
    localparam int AW = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [4:0] ev = '0;
    logic rx_pending = 1'b0;
    logic irq, bus_summary, rx_continue;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_irq_unit u_i2c_irq_unit (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_tx_ack(ev[0]), .ev_tx_nak(ev[1]), .ev_rx_done(ev[2]),
        .ev_stop_bad(ev[3]), .ev_stop_ok(ev[4]), .rx_pending(rx_pending),
        .irq(irq), .bus_summary(bus_summary), .rx_continue(rx_continue)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: optional write plus event vector, sampled 1 ns after the edge.
    task automatic step(bit do_wr, logic [AW-1:0] a, logic [31:0] d, logic [4:0] e);
        @(negedge clk);
        reg_valid = do_wr; reg_write = do_wr; reg_addr = a; reg_wdata = d; ev = e;
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0; ev = '0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        step(1'b1, a, d, 5'b0);
    endtask

    task automatic pulse(logic [4:0] e);
        step(1'b0, '0, '0, e);
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic chk_st(string req, logic [31:0] exp);
        logic [31:0] v;
        rd(4'd1, v);
        chk(req, v, exp);
    endtask

    task automatic chk_irq(string req, logic exp);
        chk({req, " irq"}, {31'b0, irq}, {31'b0, exp});
        chk({req, " summary"}, {31'b0, bus_summary}, {31'b0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); chk("R1 enable", v, 0);
        chk_st("R1 status", 0);
        chk_irq("R1", 1'b0);
        chk("R1 cont", {31'b0, rx_continue}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); chk("R2 mask", v, 32'h0000_7FFF);
        wr(4'd0, 32'h0000_001F);
        rd(4'd0, v); chk("R2 value", v, 32'h1F);
    endtask

    task automatic t_set_clear();
        pulse(5'b00001);
        chk_st("R3 ack", 32'h1); chk_irq("R3", 1'b1);
        pulse(5'b10010);
        chk_st("R3 nak+ok", 32'h13);
        wr(4'd1, 32'h2);
        chk_st("R6 clear one", 32'h11); chk_irq("R7 still", 1'b1);
        wr(4'd1, 32'hFFFF_8000);
        chk_st("R6 upper ignored", 32'h11);
        wr(4'd1, 32'h11);
        chk_st("R6 clear all", 32'h0); chk_irq("R7 drop", 1'b0);
    endtask

    task automatic t_disabled();
        wr(4'd0, 32'h1);
        pulse(5'b00100);
        chk_st("R4 dropped", 32'h0); chk_irq("R4", 1'b0);
    endtask

    task automatic t_purge();
        wr(4'd0, 32'h1F);
        pulse(5'b00010);
        chk_st("R5 setup", 32'h2);
        wr(4'd0, 32'h1);
        chk_st("R5 held until event", 32'h2);
        pulse(5'b00001);
        chk_st("R5 purged", 32'h1);
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h1F);
    endtask

    task automatic t_race();
        pulse(5'b00001);
        step(1'b1, 4'd1, 32'h1, 5'b00001);
        chk_st("R8 event wins", 32'h1); chk_irq("R8", 1'b1);
        wr(4'd1, 32'h1);
        chk_irq("R8 cleared", 1'b0);
    endtask

    task automatic t_resume();
        rx_pending = 1'b1;
        pulse(5'b00100);
        chk_st("R9 setup", 32'h4);
        wr(4'd1, 32'h4);
        chk("R9 pulse", {31'b0, rx_continue}, 1);
        chk_st("R9 cleared", 32'h0);
        @(posedge clk); #1;
        chk("R9 one cycle", {31'b0, rx_continue}, 0);
    endtask

    task automatic t_no_resume();
        rx_pending = 1'b0;
        pulse(5'b00100);
        wr(4'd1, 32'h4);
        chk("R10 not pending", {31'b0, rx_continue}, 0);
        rx_pending = 1'b1;
        wr(4'd1, 32'h4);
        chk("R10 not held", {31'b0, rx_continue}, 0);
        pulse(5'b00100);
        wr(4'd1, 32'h1);
        chk("R10 bit2 zero", {31'b0, rx_continue}, 0);
        chk_st("R10 rx_done kept", 32'h4);
        rx_pending = 1'b0;
        wr(4'd1, 32'h4);
    endtask

    task automatic t_read();
        logic [31:0] a, b;
        pulse(5'b01000);
        rd(4'd1, a);
        @(posedge clk); #1;
        rd(4'd1, b);
        chk("R11 no side effect", b, a);
        chk("R11 value", b, 32'h8);
        chk_irq("R11", 1'b1);
        rd(4'd5, a);
        chk("R11 unmapped", a, 0);
        wr(4'd1, 32'h8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_enable();
        t_set_clear();
        t_disabled();
        t_purge();
        t_race();
        t_resume();
        t_no_resume();
        t_read();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule